// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns a two-word interrupt command into the set of target units that should receive it. Software or a neighbouring block first writes the high command word, which holds the destination, and then the low command word, which carries the vector, the delivery mode, the addressing mode, the level and trigger bits, and a destination shorthand. Writing the low word starts one resolution. Writing the high word only stores the destination.

Each of up to eight targets presents three values: a physical ID, a logical ID and a destination-format model. The resolver matches the destination against every target in parallel. It supports physical addressing with a broadcast value, flat logical addressing and cluster logical addressing. It then applies the shorthand and the lowest-priority reduction. One cycle after the low-word write it presents the target mask, delivery mode, vector and trigger mode with a one-cycle valid pulse. An INIT command with level deasserted and level trigger is a special case: it selects no targets and raises a one-cycle arbitration-reload pulse in place of the valid pulse.

Top module: `irq_dest_resolver`

## Requirements
- R1: A low-word write in one cycle gives a one-cycle `dlv_valid` pulse in the next cycle. With that pulse, `dlv_vector` is bits 7:0 of the low word, `dlv_mode` is bits 10:8 and `dlv_trigger` is bit 15. The pulse drops in the following cycle unless another low word is written.
- R2: A high-word write stores bits 31:24 as the destination and produces neither `dlv_valid` nor `arb_reload`. Later low-word writes use the stored destination.
- R3: The shorthand is in low-word bits 19:18. Code 0 uses the addressed destination. Code 1 selects only the target at index `self_idx`. Code 2 selects all targets. Code 3 selects all targets except `self_idx`. A nonzero shorthand ignores the destination and the addressing mode.
- R4: Physical addressing is low-word bit 11 = 0. Destination 8'hFF selects every target. Any other destination selects each target whose physical ID equals it.
- R5: Logical addressing is bit 11 = 1. A target with model 4'hF is selected when the destination ANDed with its logical ID is nonzero.
- R6: In logical addressing, a target with model 4'h0 is selected when the upper nibbles of the destination and the logical ID are equal and their lower nibbles share at least one set bit.
- R7: In logical addressing, a target whose model is neither 4'h0 nor 4'hF is never selected.
- R8: When the delivery mode is 3'b001 (lowest priority), the presented mask keeps only the lowest-numbered selected target. An empty selection stays empty.
- R9: When the delivery mode is 3'b101 (INIT), bit 14 is 0 and bit 15 is 1, there is no `dlv_valid` pulse. Instead `arb_reload` pulses for one cycle. Any other INIT command is delivered normally.
- R10: After synchronous reset, `dlv_valid`, `arb_reload` and `dlv_mask` are 0 and the stored destination is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi_we | input | 1 | Write strobe for the high command word |
| cmd_lo_we | input | 1 | Write strobe for the low command word; starts a resolution |
| cmd_wdata | input | 32 | Command word data |
| self_idx | input | 3 | Index of the issuing unit, used by the shorthands |
| tgt_id | input | 64 | Physical ID of each target, 8 bits per target, target 0 lowest |
| tgt_logid | input | 64 | Logical ID of each target, 8 bits per target |
| tgt_model | input | 32 | Destination-format model of each target, 4 bits per target |
| dlv_valid | output | 1 | One-cycle pulse marking a resolved delivery |
| dlv_mask | output | 8 | Selected targets, bit i for target i |
| dlv_mode | output | 3 | Delivery mode of the resolved command |
| dlv_vector | output | 8 | Vector of the resolved command |
| dlv_trigger | output | 1 | Trigger mode of the resolved command |
| arb_reload | output | 1 | One-cycle pulse requesting reload of arbitration IDs |

## Verification
The main check drives several hundred random commands, each against a freshly randomised target table. The physical IDs are drawn from a small range, so duplicates and misses both occur. The models mix flat, cluster and undefined codes. The destinations are biased toward existing IDs, logical IDs and the broadcast value, so that each matching rule is hit both ways. Directed cases separate the effects that random mixing can hide. A cluster destination shares the lower-nibble bits but differs in the upper nibble. An undefined model has a logical ID that would match under flat rules. A lowest-priority command has an empty selection and another has several selected targets. An INIT command is sent with both the reload combination and a neighbouring bit combination. The self-excluding shorthand is sent with every target's ID equal to the destination, which shows that the shorthand overrides addressing.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    localparam int DEST_W  = 8;
    localparam int HALF_W  = DEST_W / 2;
    localparam int MODEL_W = 4;

    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [2:0] {
        DM_FIXED   = 3'd0,
        DM_LOWPRI  = 3'd1,
        DM_SMI     = 3'd2,
        DM_RSVD    = 3'd3,
        DM_NMI     = 3'd4,
        DM_INIT    = 3'd5,
        DM_STARTUP = 3'd6,
        DM_EXTINT  = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [7:0]        vector;
        dlv_mode_e         mode;
        logic              logical;
        logic              level;
        logic              trigger;
        shorthand_e        shorthand;
        logic [DEST_W-1:0] dest;
    } irq_cmd_t;

    function automatic irq_cmd_t unpack_cmd(input logic [31:0] lo_word,
                                            input logic [DEST_W-1:0] dest);
        irq_cmd_t c;
        c.vector    = lo_word[7:0];
        c.mode      = dlv_mode_e'(lo_word[10:8]);
        c.logical   = lo_word[11];
        c.level     = lo_word[14];
        c.trigger   = lo_word[15];
        c.shorthand = shorthand_e'(lo_word[19:18]);
        c.dest      = dest;
        return c;
    endfunction

    function automatic logic is_reload_cmd(input irq_cmd_t c);
        return (c.mode == DM_INIT) && !c.level && c.trigger;
    endfunction

endpackage

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
    import irq_dest_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hi_we,
    input  logic        lo_we,
    input  logic [31:0] wdata,
    output irq_cmd_t    cmd,
    output logic        go
);
    logic [DEST_W-1:0] dest_q;
    logic              unused_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q <= '0;
        end else if (hi_we) begin
            dest_q <= wdata[31:32-DEST_W];
        end
    end

    assign unused_bits = ^{wdata[13:12], wdata[17:16], wdata[31:20]};
    assign cmd = unpack_cmd(wdata, dest_q);
    assign go  = lo_we;

endmodule

// File: rtl/irq_target_matcher.sv
module irq_target_matcher
    import irq_dest_pkg::*;
#(
    parameter int NUM_TGT = 8
) (
    input  logic [DEST_W-1:0]          dest,
    input  logic                       logical,
    input  logic [NUM_TGT*DEST_W-1:0]  tgt_id,
    input  logic [NUM_TGT*DEST_W-1:0]  tgt_logid,
    input  logic [NUM_TGT*MODEL_W-1:0] tgt_model,
    output logic [NUM_TGT-1:0]         hit
);
    localparam logic [DEST_W-1:0] BCAST = '1;

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
        logic [DEST_W-1:0]  id_i;
        logic [DEST_W-1:0]  log_i;
        logic [MODEL_W-1:0] model_i;
        logic               phys_hit;
        logic               flat_hit;
        logic               clus_hit;
        logic               log_hit;

        assign id_i    = tgt_id[i*DEST_W +: DEST_W];
        assign log_i   = tgt_logid[i*DEST_W +: DEST_W];
        assign model_i = tgt_model[i*MODEL_W +: MODEL_W];

        assign phys_hit = (dest == BCAST) || (id_i == dest);
        assign flat_hit = |(dest & log_i);
        assign clus_hit = (dest[DEST_W-1:HALF_W] == log_i[DEST_W-1:HALF_W]) &&
                          (|(dest[HALF_W-1:0] & log_i[HALF_W-1:0]));

        always_comb begin
            case (model_i)
                MODEL_FLAT:    log_hit = flat_hit;
                MODEL_CLUSTER: log_hit = clus_hit;
                default:       log_hit = 1'b0;
            endcase
        end

        assign hit[i] = logical ? log_hit : phys_hit;
    end

endmodule

// File: rtl/irq_mask_finalizer.sv
module irq_mask_finalizer
    import irq_dest_pkg::*;
#(
    parameter int NUM_TGT = 8,
    localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  irq_cmd_t           cmd,
    input  logic [NUM_TGT-1:0] addr_mask,
    input  logic [IDX_W-1:0]   self_idx,
    output logic               valid,
    output logic               reload,
    output logic [NUM_TGT-1:0] mask,
    output dlv_mode_e          mode,
    output logic [7:0]         vector,
    output logic               trigger
);
    logic [NUM_TGT-1:0] self_bit;
    logic [NUM_TGT-1:0] sel_mask;
    logic [NUM_TGT-1:0] fin_mask;
    logic               is_reload;
    logic               unused_cmd;

    assign self_bit   = NUM_TGT'(1) << self_idx;
    assign is_reload  = is_reload_cmd(cmd);
    assign unused_cmd = ^{cmd.dest, cmd.logical};

    always_comb begin
        case (cmd.shorthand)
            SH_SELF:   sel_mask = self_bit;
            SH_ALL:    sel_mask = '1;
            SH_OTHERS: sel_mask = ~self_bit;
            default:   sel_mask = addr_mask;
        endcase
    end

    assign fin_mask = (cmd.mode == DM_LOWPRI) ? (sel_mask & (~sel_mask + NUM_TGT'(1)))
                                              : sel_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            reload  <= 1'b0;
            mask    <= '0;
            mode    <= DM_FIXED;
            vector  <= '0;
            trigger <= 1'b0;
        end else begin
            valid  <= go && !is_reload;
            reload <= go && is_reload;
            if (go && !is_reload) begin
                mask    <= fin_mask;
                mode    <= cmd.mode;
                vector  <= cmd.vector;
                trigger <= cmd.trigger;
            end
        end
    end

    // R1: a pulse appears only after a low-word write
    assert_pulse_cause_R1: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(go));

    // R8: lowest-priority delivery never names more than one target
    assert_lowpri_single_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == DM_LOWPRI) |-> $onehot0(mask));

    // R9: reload and delivery never coincide
    assert_reload_excl_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({valid, reload}));

    // R3: all-but-self shorthand never includes the sender
    assert_others_skip_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(cmd.shorthand == SH_OTHERS)) |-> !mask[$past(self_idx)]);

    // R3: self shorthand names exactly one target
    assert_self_one_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(cmd.shorthand == SH_SELF)) |-> ($countones(mask) == 1));

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int NUM_TGT = 8,
    localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_hi_we,
    input  logic                       cmd_lo_we,
    input  logic [31:0]                cmd_wdata,
    input  logic [IDX_W-1:0]           self_idx,
    input  logic [NUM_TGT*DEST_W-1:0]  tgt_id,
    input  logic [NUM_TGT*DEST_W-1:0]  tgt_logid,
    input  logic [NUM_TGT*MODEL_W-1:0] tgt_model,
    output logic                       dlv_valid,
    output logic [NUM_TGT-1:0]         dlv_mask,
    output logic [2:0]                 dlv_mode,
    output logic [7:0]                 dlv_vector,
    output logic                       dlv_trigger,
    output logic                       arb_reload
);
    irq_cmd_t           cmd;
    logic               go;
    logic [NUM_TGT-1:0] addr_mask;
    dlv_mode_e          mode_q;

    irq_cmd_decoder u_dec (
        .clk   (clk),
        .rst   (rst),
        .hi_we (cmd_hi_we),
        .lo_we (cmd_lo_we),
        .wdata (cmd_wdata),
        .cmd   (cmd),
        .go    (go)
    );

    irq_target_matcher #(.NUM_TGT(NUM_TGT)) u_match (
        .dest      (cmd.dest),
        .logical   (cmd.logical),
        .tgt_id    (tgt_id),
        .tgt_logid (tgt_logid),
        .tgt_model (tgt_model),
        .hit       (addr_mask)
    );

    irq_mask_finalizer #(.NUM_TGT(NUM_TGT)) u_fin (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cmd       (cmd),
        .addr_mask (addr_mask),
        .self_idx  (self_idx),
        .valid     (dlv_valid),
        .reload    (arb_reload),
        .mask      (dlv_mask),
        .mode      (mode_q),
        .vector    (dlv_vector),
        .trigger   (dlv_trigger)
    );

    assign dlv_mode = mode_q;

    // R2: a high-word write on its own starts nothing
    assert_hi_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_hi_we && !cmd_lo_we) |=> (!dlv_valid && !arb_reload));

endmodule

// File: tb/sim_irq_dest_resolver.sv
module sim_irq_dest_resolver;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_hi_we = 1'b0;
    logic          cmd_lo_we = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [2:0]    self_idx = '0;
    logic [N*8-1:0] tgt_id;
    logic [N*8-1:0] tgt_logid;
    logic [N*4-1:0] tgt_model;
    logic          dlv_valid;
    logic [N-1:0]  dlv_mask;
    logic [2:0]    dlv_mode;
    logic [7:0]    dlv_vector;
    logic          dlv_trigger;
    logic          arb_reload;

    logic [7:0] t_id  [N];
    logic [7:0] t_log [N];
    logic [3:0] t_mod [N];
    logic [7:0] cur_dest = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tgt_id[i*8 +: 8]    = t_id[i];
            tgt_logid[i*8 +: 8] = t_log[i];
            tgt_model[i*4 +: 4] = t_mod[i];
        end
    end

    irq_dest_resolver u0 (
        .clk(clk), .rst(rst), .cmd_hi_we(cmd_hi_we), .cmd_lo_we(cmd_lo_we),
        .cmd_wdata(cmd_wdata), .self_idx(self_idx), .tgt_id(tgt_id),
        .tgt_logid(tgt_logid), .tgt_model(tgt_model), .dlv_valid(dlv_valid),
        .dlv_mask(dlv_mask), .dlv_mode(dlv_mode), .dlv_vector(dlv_vector),
        .dlv_trigger(dlv_trigger), .arb_reload(arb_reload)
    );

    function automatic logic [N-1:0] ref_mask(input logic [31:0] lo);
        logic [N-1:0] m = '0;
        logic [1:0] sh = lo[19:18];
        for (int i = 0; i < N; i++) begin
            if (!lo[11]) begin
                m[i] = (cur_dest == 8'hFF) || (t_id[i] == cur_dest);
            end else if (t_mod[i] == 4'hF) begin
                m[i] = (cur_dest & t_log[i]) != 8'h00;
            end else if (t_mod[i] == 4'h0) begin
                m[i] = (cur_dest[7:4] == t_log[i][7:4]) &&
                       ((cur_dest[3:0] & t_log[i][3:0]) != 4'h0);
            end
        end
        if (sh == 2'd1) m = '0;
        if (sh == 2'd2) m = '1;
        if (sh == 2'd3) m = '1;
        if (sh == 2'd1) m[self_idx] = 1'b1;
        if (sh == 2'd3) m[self_idx] = 1'b0;
        if (lo[10:8] == 3'b001) begin
            logic found = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (found) m[i] = 1'b0;
                else if (m[i]) found = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic string tag_of(input logic [31:0] lo);
        if (lo[10:8] == 3'b101 && !lo[14] && lo[15]) return "R9";
        if (lo[10:8] == 3'b001) return "R8";
        if (lo[19:18] != 2'd0) return "R3";
        if (!lo[11]) return "R4";
        return "R5_R6_R7";
    endfunction

    task automatic check(input string tag, input logic ok,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_hi(input logic [7:0] d);
        @(negedge clk);
        cmd_hi_we = 1'b1;
        cmd_wdata = {d, 24'($urandom)};
        @(negedge clk);
        cmd_hi_we = 1'b0;
        cur_dest = d;
        check("R2", !dlv_valid && !arb_reload, {dlv_valid, arb_reload}, 0);
    endtask

    task automatic send(input logic [31:0] lo, input string tag);
        logic [N-1:0] em;
        logic reload_exp;
        em = ref_mask(lo);
        reload_exp = (lo[10:8] == 3'b101) && !lo[14] && lo[15];
        @(negedge clk);
        cmd_lo_we = 1'b1;
        cmd_wdata = lo;
        @(negedge clk);
        cmd_lo_we = 1'b0;
        if (reload_exp)
            check(tag, !dlv_valid && arb_reload, {dlv_valid, arb_reload}, 2'b01);
        else
            check(tag, dlv_valid && !arb_reload && dlv_mask == em &&
                       dlv_mode == lo[10:8] && dlv_vector == lo[7:0] &&
                       dlv_trigger == lo[15],
                  {dlv_valid, arb_reload, dlv_mask, dlv_mode, dlv_vector, dlv_trigger},
                  {2'b10, em, lo[10:8], lo[7:0], lo[15]});
        @(negedge clk);
        check("R1", !dlv_valid && !arb_reload, {dlv_valid, arb_reload}, 0);
    endtask

    function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] dm,
                                       input logic lg, input logic lvl,
                                       input logic trg, input logic [1:0] sh);
        return {12'h000, sh, 2'b00, trg, lvl, 2'b00, lg, dm, vec};
    endfunction

    task automatic randomize_targets();
        for (int i = 0; i < N; i++) begin
            int r = int'($urandom % 3);
            t_id[i]  = 8'($urandom % 12);
            t_log[i] = 8'($urandom);
            t_mod[i] = (r == 0) ? 4'hF : (r == 1) ? 4'h0 : 4'($urandom % 14 + 1);
        end
        self_idx = 3'($urandom);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            t_id[i] = 8'(i); t_log[i] = 8'(1 << i); t_mod[i] = 4'hF;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10", !dlv_valid && !arb_reload && dlv_mask == '0,
              {dlv_valid, arb_reload, dlv_mask}, 0);
        // R10: stored destination resets to 0, so physical dest 0 hits target 0
        send(mk(8'h21, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), "R10");

        // R4 directed: broadcast, single ID, duplicate IDs
        write_hi(8'hFF);
        send(mk(8'h30, 3'd0, 1'b0, 1'b1, 1'b0, 2'd0), "R4");
        write_hi(8'h05);
        send(mk(8'h31, 3'd4, 1'b0, 1'b0, 1'b1, 2'd0), "R4");
        t_id[2] = 8'h05;
        send(mk(8'h32, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), "R4");

        // R5 flat and R7 undefined model
        write_hi(8'h0C);
        send(mk(8'h40, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), "R5");
        t_mod[3] = 4'h5;
        send(mk(8'h41, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), "R7");

        // R6 cluster: upper nibble mismatch vs match
        for (int i = 0; i < N; i++) t_mod[i] = 4'h0;
        t_log[0] = 8'h23; t_log[1] = 8'h33; t_log[2] = 8'h34;
        write_hi(8'h31);
        send(mk(8'h50, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), "R6");

        // R8: several selected and empty selection
        write_hi(8'hFF);
        send(mk(8'h60, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0), "R8");
        write_hi(8'hEE);
        send(mk(8'h61, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0), "R8");

        // R9: reload combination and neighbour combination
        send(mk(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd2), "R9");
        send(mk(8'h00, 3'd5, 1'b0, 1'b1, 1'b1, 2'd2), "R9");

        // R3: shorthand overrides addressing even when every ID matches
        for (int i = 0; i < N; i++) t_id[i] = 8'h07;
        write_hi(8'h07);
        self_idx = 3'd4;
        send(mk(8'h70, 3'd0, 1'b0, 1'b0, 1'b0, 2'd3), "R3");
        send(mk(8'h71, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1), "R3");
        send(mk(8'h72, 3'd0, 1'b1, 1'b0, 1'b0, 2'd2), "R3");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [31:0] lo;
            int pick;
            randomize_targets();
            pick = int'($urandom % 4);
            if (k % 5 == 0) begin
                case (pick)
                    0: write_hi(8'hFF);
                    1: write_hi(t_id[$urandom % N]);
                    2: write_hi(t_log[$urandom % N]);
                    default: write_hi(8'($urandom));
                endcase
            end
            lo = $urandom;
            if ($urandom % 2 == 0) lo[19:18] = 2'd0;
            send(lo, tag_of(lo));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule